// File: doc/BRIEF.md
# Two-Wire Bus Control Register with Bit Counter

This block holds the configuration byte for a two-wire serial bus interface. It stores four mode bits: interface enable, free-data versus addressed format, 10-bit versus 7-bit addressing, and SMBus versus standard input thresholds. It also holds a 3-bit field that sets how many bits one transfer carries. The count is stored inverted, so the value zero means a full byte.

A tracker counts the bit-shift strobes that the shifter raises. It reports how many bits of the current transfer are still to come, and it raises a done flag when none remain. A start or stop detection clears both the stored count field and the tracker's progress, and so does the end of a whole byte in either direction.

Writing one to the reset bit sends a pulse to the protocol core. The pulse lasts five half-periods of the interface clock, which are counted on a double-rate enable. The bit then falls back to zero by itself.

Top module: `sbus_ctrl_reg`

## Requirements
- R1: After reset, rd_data is 0x00, all mode outputs are 0, core_rst is 0, bits_total and bits_left are 8, and count_done is 0.
- R2: A write stores wr_data in the following layout, and rd_data returns it: bit7 SMBus levels, bit5 10-bit addressing, bit4 free format, bit3 enable, bits 2:0 count field. Each mode bit also drives its own output.
- R3: The transfer length bits_total equals 8 minus the count field, so 000 gives 8 and 111 gives 1.
- R4: Each bit_shift strobe lowers bits_left by one. When bits_left reaches 0, count_done is 1 and further strobes leave the tracker unchanged.
- R5: A start_stop_det or byte_done strobe clears the count field to 000 and resets progress, so bits_left returns to 8 on the next cycle.
- R6: A clear has priority over a bit_shift strobe and over a count-field write in the same cycle. The mode bits of that write are still stored.
- R7: Writing 1 to bit6 raises core_rst on the next cycle. core_rst falls right after the fifth half_tick that follows, and stays high while no half_tick arrives.
- R8: A write of 1 to bit6 while core_rst is high neither restarts nor lengthens the pulse.
- R9: rd_data bit6 reads 1 while the pulse runs and 0 once it has ended. A write with bit6 at 0 starts no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Register read value |
| half_tick | input | 1 | Enable pulsed once per interface-clock half-period |
| bit_shift | input | 1 | One bit shifted by the serial engine |
| start_stop_det | input | 1 | Start or stop condition seen |
| byte_done | input | 1 | Whole byte sent or received |
| if_enable | output | 1 | Interface enable |
| free_format | output | 1 | Free data format selected |
| addr_10bit | output | 1 | 10-bit addressing selected |
| smbus_levels | output | 1 | SMBus input thresholds selected |
| bits_total | output | 4 | Bits per transfer, 1 to 8 |
| bits_left | output | 4 | Bits still to shift |
| count_done | output | 1 | Programmed bit count reached |
| core_rst | output | 1 | Reset pulse to the protocol core |

## Verification
A clear strobe can land in the same cycle as a bit_shift strobe, and it can also land on a write that carries a new count field. Stimulus vectors raise these inputs together on one edge. The bench then checks that bits_left is back to 8 and that the count field reads 000, while the mode bits of the write are kept. A second overlap is a reset-bit write that arrives while a pulse is running. The bench checks that release still follows the fifth half_tick of the original pulse.

// File: rtl/sbus_ctrl_pkg.sv
package sbus_ctrl_pkg;
  localparam int REG_W   = 8;
  localparam int CNT_W   = 3;
  localparam int TOT_W   = CNT_W + 1;
  localparam int POS_EN  = 3;
  localparam int POS_FMT = 4;
  localparam int POS_A10 = 5;
  localparam int POS_RST = 6;
  localparam int POS_SMB = 7;

  typedef struct packed {
    logic             smbus;
    logic             addr10;
    logic             free_fmt;
    logic             enable;
    logic [CNT_W-1:0] bc;
  } cfg_t;
endpackage

// File: rtl/sbus_cfg_fields.sv
module sbus_cfg_fields
  import sbus_ctrl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  input  logic             clr,
  output cfg_t             cfg
);
  cfg_t cfg_q, cfg_d;

  always_comb begin
    cfg_d = cfg_q;
    if (wr_en) begin
      cfg_d.enable   = wr_data[POS_EN];
      cfg_d.free_fmt = wr_data[POS_FMT];
      cfg_d.addr10   = wr_data[POS_A10];
      cfg_d.smbus    = wr_data[POS_SMB];
      cfg_d.bc       = wr_data[CNT_W-1:0];
    end
    if (clr) cfg_d.bc = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '0;
    else        cfg_q <= cfg_d;
  end

  assign cfg = cfg_q;
endmodule

// File: rtl/sbus_bit_tracker.sv
module sbus_bit_tracker #(
  parameter int CW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] bc,
  input  logic          shift,
  input  logic          clr,
  output logic [CW:0]   total,
  output logic [CW:0]   left,
  output logic          done
);
  localparam logic [CW:0] FULL = (CW+1)'(1 << CW);

  logic [CW:0] cnt_q, cnt_d;

  assign total = FULL - {1'b0, bc};
  assign done  = (cnt_q >= total);
  assign left  = done ? '0 : (total - cnt_q);

  always_comb begin
    cnt_d = cnt_q;
    if (clr)                cnt_d = '0;
    else if (shift && !done) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/sbus_rst_pulse.sv
module sbus_rst_pulse #(
  parameter int HALF_CYCLES = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig,
  input  logic half_tick,
  output logic pulse
);
  localparam int HW = $clog2(HALF_CYCLES + 1);
  localparam logic [HW-1:0] LAST = HW'(HALF_CYCLES - 1);

  logic          busy_q, busy_d;
  logic [HW-1:0] hcnt_q, hcnt_d;

  always_comb begin
    busy_d = busy_q;
    hcnt_d = hcnt_q;
    if (!busy_q) begin
      if (trig) begin
        busy_d = 1'b1;
        hcnt_d = '0;
      end
    end else if (half_tick) begin
      if (hcnt_q == LAST) begin
        busy_d = 1'b0;
        hcnt_d = '0;
      end else begin
        hcnt_d = hcnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      hcnt_q <= '0;
    end else begin
      busy_q <= busy_d;
      hcnt_q <= hcnt_d;
    end
  end

  assign pulse = busy_q;
endmodule

// File: rtl/sbus_ctrl_reg.sv
module sbus_ctrl_reg
  import sbus_ctrl_pkg::*;
#(
  parameter int HALF_CYCLES = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  input  logic             half_tick,
  input  logic             bit_shift,
  input  logic             start_stop_det,
  input  logic             byte_done,
  output logic             if_enable,
  output logic             free_format,
  output logic             addr_10bit,
  output logic             smbus_levels,
  output logic [TOT_W-1:0] bits_total,
  output logic [TOT_W-1:0] bits_left,
  output logic             count_done,
  output logic             core_rst
);
  cfg_t cfg;
  logic clr;

  assign clr = start_stop_det | byte_done;

  sbus_cfg_fields u_fields (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .clr(clr), .cfg(cfg)
  );

  sbus_bit_tracker #(.CW(CNT_W)) u_track (
    .clk(clk), .rst_n(rst_n), .bc(cfg.bc), .shift(bit_shift), .clr(clr),
    .total(bits_total), .left(bits_left), .done(count_done)
  );

  sbus_rst_pulse #(.HALF_CYCLES(HALF_CYCLES)) u_rst (
    .clk(clk), .rst_n(rst_n), .trig(wr_en & wr_data[POS_RST]),
    .half_tick(half_tick), .pulse(core_rst)
  );

  assign if_enable    = cfg.enable;
  assign free_format  = cfg.free_fmt;
  assign addr_10bit   = cfg.addr10;
  assign smbus_levels = cfg.smbus;

  always_comb begin
    rd_data            = '0;
    rd_data[CNT_W-1:0] = cfg.bc;
    rd_data[POS_EN]    = cfg.enable;
    rd_data[POS_FMT]   = cfg.free_fmt;
    rd_data[POS_A10]   = cfg.addr10;
    rd_data[POS_RST]   = core_rst;
    rd_data[POS_SMB]   = cfg.smbus;
  end
endmodule

// File: rtl/sbus_ctrl_reg_chk.sv
module sbus_ctrl_reg_chk #(
  parameter int HALF_CYCLES = 5
) (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [7:0] wr_data,
  input logic [7:0] rd_data,
  input logic       half_tick,
  input logic       bit_shift,
  input logic       start_stop_det,
  input logic       byte_done,
  input logic [3:0] bits_left,
  input logic       count_done,
  input logic       core_rst
);
  localparam int CW = $clog2(HALF_CYCLES + 2);
  logic [CW-1:0] ticks;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         ticks <= '0;
    else if (!core_rst) ticks <= '0;
    else if (half_tick) ticks <= ticks + 1'b1;
  end

  // R4
  shift_decrements_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_shift && !start_stop_det && !byte_done && !wr_en && !count_done)
      |=> bits_left == $past(bits_left) - 4'd1);

  // R4
  done_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (count_done && !start_stop_det && !byte_done && !wr_en) |=> count_done);

  // R5
  clear_restores_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_stop_det || byte_done) |=> (bits_left == 4'd8 && rd_data[2:0] == 3'd0));

  // R7
  pulse_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(core_rst) |-> $past(wr_en && wr_data[6]));

  // R7
  pulse_short_chk: assert property (@(posedge clk) disable iff (!rst_n)
    core_rst |-> int'(ticks) < HALF_CYCLES);

  // R8
  pulse_length_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(core_rst) |-> int'(ticks) == HALF_CYCLES);

  // R9
  read_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[6] == core_rst);
endmodule

bind sbus_ctrl_reg sbus_ctrl_reg_chk #(.HALF_CYCLES(HALF_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
  .rd_data(rd_data), .half_tick(half_tick), .bit_shift(bit_shift),
  .start_stop_det(start_stop_det), .byte_done(byte_done),
  .bits_left(bits_left), .count_done(count_done), .core_rst(core_rst)
);

// File: tb/sbus_ctrl_reg_test.sv
`timescale 1ns/1ps
module sbus_ctrl_reg_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic       half_tick = 1'b0, bit_shift = 1'b0, start_stop_det = 1'b0, byte_done = 1'b0;
  logic       if_enable, free_format, addr_10bit, smbus_levels, count_done, core_rst;
  logic [3:0] bits_total, bits_left;
  int n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;

  sbus_ctrl_reg uut (.*);

  // {wr, wdata, shift, ss, bd, exp_rd, exp_left, exp_done}
  localparam int NV = 11;
  localparam logic [24:0] VEC [NV] = '{
    {1'b1, 8'h38, 1'b0, 1'b0, 1'b0, 8'h38, 4'd8, 1'b0},
    {1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 8'h38, 4'd7, 1'b0},
    {1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 8'h38, 4'd6, 1'b0},
    {1'b1, 8'h3E, 1'b0, 1'b0, 1'b0, 8'h3E, 4'd0, 1'b1},
    {1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 8'h3E, 4'd0, 1'b1},
    {1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 8'h38, 4'd8, 1'b0},
    {1'b0, 8'h00, 1'b1, 1'b1, 1'b0, 8'h38, 4'd8, 1'b0},
    {1'b1, 8'hBF, 1'b0, 1'b0, 1'b1, 8'hB8, 4'd8, 1'b0},
    {1'b1, 8'h87, 1'b0, 1'b0, 1'b0, 8'h87, 4'd1, 1'b0},
    {1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 8'h87, 4'd0, 1'b1},
    {1'b1, 8'h80, 1'b0, 1'b0, 1'b0, 8'h80, 4'd7, 1'b0}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cyc(input logic w, input logic [7:0] d, input logic sh,
                     input logic ss, input logic bd, input logic ht);
    @(negedge clk);
    wr_en = w; wr_data = d; bit_shift = sh; start_stop_det = ss; byte_done = bd; half_tick = ht;
    @(posedge clk);
    #1;
    @(negedge clk);
    wr_en = 0; bit_shift = 0; start_stop_det = 0; byte_done = 0; half_tick = 0;
  endtask

  initial begin
    #(4 * 200000);
    n_bad++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk("R1 rd", rd_data, 8'h00);
    chk("R1 modes", {4'd0, if_enable, free_format, addr_10bit, smbus_levels}, 8'h00);
    chk("R1 left", {4'd0, bits_left}, 8'd8);
    chk("R1 total", {4'd0, bits_total}, 8'd8);
    chk("R1 done/rst", {6'd0, count_done, core_rst}, 8'h00);
    @(negedge clk);
    rst_n = 1'b1;

    // table: R2 R3 R4 R5 R6
    for (int i = 0; i < NV; i++) begin
      logic [24:0] v;
      v = VEC[i];
      cyc(v[24], v[23:16], v[15], v[14], v[13], 1'b0);
      chk("R2 R5 R6 rd", rd_data, v[12:5]);
      chk("R3 R4 R6 left", {4'd0, bits_left}, {4'd0, v[4:1]});
      chk("R4 done", {7'd0, count_done}, {7'd0, v[0]});
    end

    // R2 R3 decoded fields
    cyc(1, 8'h05, 0, 0, 0, 0);
    chk("R3 total 101", {4'd0, bits_total}, 8'd3);
    chk("R2 modes off", {4'd0, if_enable, free_format, addr_10bit, smbus_levels}, 8'h00);
    cyc(1, 8'h08, 0, 0, 0, 0);
    chk("R2 enable", {7'd0, if_enable}, 8'd1);
    chk("R3 total 000", {4'd0, bits_total}, 8'd8);
    cyc(1, 8'hB0, 0, 0, 0, 0);
    chk("R2 modes on", {4'd0, if_enable, free_format, addr_10bit, smbus_levels}, 8'h07);

    // R7 R8 R9 reset pulse
    cyc(1, 8'hC0, 0, 0, 0, 0);
    chk("R7 pulse start", {7'd0, core_rst}, 8'd1);
    chk("R9 read during", rd_data, 8'hC0);
    for (int k = 0; k < 3; k++) cyc(0, 8'h00, 0, 0, 0, 0);
    chk("R7 holds no tick", {7'd0, core_rst}, 8'd1);
    for (int k = 0; k < 4; k++) cyc(0, 8'h00, 0, 0, 0, 1);
    chk("R7 after 4 ticks", {7'd0, core_rst}, 8'd1);
    cyc(1, 8'hC0, 0, 0, 0, 0);
    chk("R8 rewrite", {7'd0, core_rst}, 8'd1);
    cyc(0, 8'h00, 0, 0, 0, 1);
    chk("R8 release on 5th", {7'd0, core_rst}, 8'd0);
    chk("R9 read after", rd_data, 8'h80);
    cyc(1, 8'h00, 0, 0, 0, 0);
    chk("R9 bit6 zero", {7'd0, core_rst}, 8'd0);
    cyc(1, 8'h40, 0, 0, 0, 0);
    chk("R7 second pulse", {7'd0, core_rst}, 8'd1);
    for (int k = 0; k < 5; k++) cyc(0, 8'h00, 0, 0, 0, 1);
    chk("R7 second release", {7'd0, core_rst}, 8'd0);
    chk("R9 read zero", rd_data, 8'h00);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule